// File: doc/BRIEF.md
# Nibble-Serial Flash Bus Write Target

This block is the target side of a 4-bit multiplexed flash bus. It handles single-byte write cycles only. It watches an active-low framing strobe and the incoming half of a 4-bit bidirectional bus. A write cycle opens when the strobe is low and the bus carries the write start code.

**Frame sequence.** After the start code come:
- a device-select nibble, which is compared with strapped ID pins;
- seven address nibbles;
- a size nibble;
- two data nibbles;
- a two-clock bus turnaround.

The target then drives a ready sync code for one clock and releases the bus.

**States and transitions.** The controller has nine enumerated states:
- IDLE waits for a start.
- ID compares the select nibble. A match goes to ADDR; a mismatch goes to IDLE.
- ADDR counts seven nibbles and then goes to SIZE.
- SIZE goes to DLO on a one-byte code and to IDLE on any other code.
- DLO goes to DHI.
- DHI goes to TAR0.
- TAR0 goes to TAR1.
- TAR1 goes to SYNC.
- SYNC goes to IDLE.

There is also one transition that overrides all of these. From any state, a low strobe moves the controller to ID if the bus carries the start code and to IDLE otherwise.

**Outputs.** The bus is modelled as separate input, output and output-enable signals. The captured address and data byte are presented together with a one-clock write pulse. That pulse is high during the clock in which the sync code is on the bus.

Top module: `nsw_write_target`

## Requirements
- R1: A cycle opens only on a clock where `frame_n` is low and `bus_in` equals 4'b1110. A low-strobe nibble with any other value (for example 4'b1101) leaves the target idle, and the frame that follows produces no drive and no write pulse.
- R2: If several start nibbles arrive while `frame_n` stays low, only the last one before `frame_n` rises counts. Any earlier low-strobe nibbles of other values are discarded, and the ID nibble is taken on the first clock with `frame_n` high.
- R3: If the ID nibble differs from `id_strap`, the target returns to idle. It never asserts `bus_oe` and never pulses `wr_valid` for that frame.
- R4: The seven nibbles after the ID form `wr_addr[27:0]`, with the most-significant nibble first. The address is held unchanged while `wr_valid` is high.
- R5: A size nibble other than 4'b0000 abandons the cycle, with no drive and no write pulse.
- R6: The first data nibble becomes `wr_data[3:0]` and the second becomes `wr_data[7:4]`.
- R7: During the first turnaround clock (frame clock 13), `bus_oe` stays low. During the second (frame clock 14), `bus_oe` is high and `bus_out` is 4'b1111.
- R8: In frame clock 15, counted from the start nibble as clock 1, `bus_oe` is high and `bus_out` is 4'b0000. On the next clock `bus_oe` is low again.
- R9: `wr_valid` is high for exactly that one sync clock of each accepted frame, and `wr_addr`/`wr_data` carry the frame's values while it is high.
- R10: A start code seen with `frame_n` low at any point of a cycle aborts that cycle and restarts decoding from the ID nibble. The aborted cycle produces no write.
- R11: While `rst_n` is low and after its release, the target is idle, with `bus_oe` and `wr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low framing strobe from the host |
| bus_in | input | 4 | Nibble received from the shared bus |
| id_strap | input | 4 | Strapped device identity |
| bus_out | output | 4 | Nibble the target drives onto the bus |
| bus_oe | output | 1 | High while the target owns the bus |
| wr_addr | output | 28 | Captured write address |
| wr_data | output | 8 | Captured data byte |
| wr_valid | output | 1 | One-clock pulse marking an accepted write |

## Verification
The bench's reference model tracks frame position as a plain integer and compares the expected ownership of the bus and the driven nibble on every clock. A design that drives during the first turnaround clock would contend with the host, and one that holds the bus after the sync clock would block the next cycle; both show up as `bus_oe` mismatches. Frames with a wrong ID, a wrong size nibble, a non-start low-strobe nibble, or an abort in the middle of the address must leave no write behind. A design that checks ID or size too loosely would produce a stray `wr_valid`, caught by the expected-write queue. Repeated start nibbles and swapped data or address nibble order surface as an address or data mismatch against the queued expectation.

// File: rtl/nsw_pkg.sv
package nsw_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] CODE_START = 4'b1110;
    localparam logic [NIB_W-1:0] CODE_SIZE1 = 4'b0000;
    localparam logic [NIB_W-1:0] CODE_READY = 4'b0000;
    localparam logic [NIB_W-1:0] CODE_HIGH  = 4'b1111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_SIZE,
        ST_DLO,
        ST_DHI,
        ST_TAR0,
        ST_TAR1,
        ST_SYNC
    } nsw_state_e;

endpackage

// File: rtl/nsw_frame_fsm.sv
module nsw_frame_fsm
    import nsw_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [NIB_W-1:0] bus_in,
    input  logic [NIB_W-1:0] id_strap,
    output nsw_state_e       state,
    output logic             drive_en,
    output logic [NIB_W-1:0] drive_nib,
    output logic             wr_pulse
);

    localparam int CNT_W = (ADDR_NIBBLES > 1) ? $clog2(ADDR_NIBBLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBBLES - 1);

    nsw_state_e       nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (!frame_n) begin
            nxt     = (bus_in == CODE_START) ? ST_ID : ST_IDLE;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ID: begin
                    nxt     = (bus_in == id_strap) ? ST_ADDR : ST_IDLE;
                    cnt_nxt = '0;
                end
                ST_ADDR: begin
                    if (cnt == CNT_LAST) begin
                        nxt     = ST_SIZE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                ST_SIZE: nxt = (bus_in == CODE_SIZE1) ? ST_DLO : ST_IDLE;
                ST_DLO:  nxt = ST_DHI;
                ST_DHI:  nxt = ST_TAR0;
                ST_TAR0: nxt = ST_TAR1;
                ST_TAR1: nxt = ST_SYNC;
                ST_SYNC: nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        drive_en  = 1'b0;
        drive_nib = CODE_HIGH;
        wr_pulse  = 1'b0;
        unique case (state)
            ST_TAR1: drive_en = 1'b1;
            ST_SYNC: begin
                drive_en  = 1'b1;
                drive_nib = CODE_READY;
                wr_pulse  = 1'b1;
            end
            default: ;
        endcase
    end

    // R3
    id_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ID && frame_n && bus_in != id_strap) |=> state == ST_IDLE);

    // R5
    size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SIZE && frame_n && bus_in != CODE_SIZE1) |=> state == ST_IDLE);

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && bus_in == CODE_START) |=> state == ST_ID);

endmodule

// File: rtl/nsw_capture.sv
module nsw_capture
    import nsw_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7,
    parameter int DATA_W       = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  nsw_state_e                 state,
    input  logic [NIB_W-1:0]           bus_in,
    output logic [ADDR_NIBBLES*NIB_W-1:0] addr_q,
    output logic [DATA_W-1:0]          data_q
);

    localparam int ADDR_W = ADDR_NIBBLES * NIB_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            unique case (state)
                ST_ADDR: addr_q <= {addr_q[ADDR_W-NIB_W-1:0], bus_in};
                ST_DLO:  data_q[NIB_W-1:0] <= bus_in;
                ST_DHI:  data_q[2*NIB_W-1:NIB_W] <= bus_in;
                default: ;
            endcase
        end
    end

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC) |-> $stable(addr_q));

endmodule

// File: rtl/nsw_write_target.sv
module nsw_write_target
    import nsw_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7,
    parameter int DATA_W       = 8,
    localparam int ADDR_W      = ADDR_NIBBLES * 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    input  logic [3:0]        id_strap,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_valid
);

    nsw_state_e state;

    nsw_frame_fsm #(.ADDR_NIBBLES(ADDR_NIBBLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .bus_in    (bus_in),
        .id_strap  (id_strap),
        .state     (state),
        .drive_en  (bus_oe),
        .drive_nib (bus_out),
        .wr_pulse  (wr_valid)
    );

    nsw_capture #(.ADDR_NIBBLES(ADDR_NIBBLES), .DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .bus_in (bus_in),
        .addr_q (wr_addr),
        .data_q (wr_data)
    );

    // R7
    tar_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !wr_valid) |-> bus_out == CODE_HIGH);

    // R8
    sync_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (bus_oe && bus_out == CODE_READY));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !bus_oe);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R7
    tar_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |=> wr_valid);

endmodule

// File: tb/nsw_write_target_test.sv
module nsw_write_target_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  bus_in = 4'hF;
    logic [3:0]  id_strap = 4'h5;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic [27:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ph = 0;                 // model frame position, 0 = idle, 14 = sync
    logic [35:0] expq[$];       // {addr, data}

    always #10 clk = ~clk;      // 50 MHz

    nsw_write_target uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
        .id_strap(id_strap), .bus_out(bus_out), .bus_oe(bus_oe),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid)
    );

    // Behavioural reference of frame position
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= 0;
        else if (!frame_n) ph <= (bus_in == 4'b1110) ? 1 : 0;
        else if (ph == 1) ph <= (bus_in == id_strap) ? 2 : 0;
        else if (ph == 9) ph <= (bus_in == 4'b0000) ? 10 : 0;
        else if (ph == 14) ph <= 0;
        else if (ph != 0) ph <= ph + 1;
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        logic exp_oe;
        logic exp_wv;
        logic [35:0] e;
        exp_oe = (ph == 13 || ph == 14);
        exp_wv = (ph == 14);
        checks++;
        if (bus_oe !== exp_oe) begin
            errors++;
            $display("FAIL R7/R8 bus_oe ph=%0d actual %b expected %b", ph, bus_oe, exp_oe);
        end
        checks++;
        if (wr_valid !== exp_wv) begin
            errors++;
            $display("FAIL R9 wr_valid ph=%0d actual %b expected %b", ph, wr_valid, exp_wv);
        end
        if (exp_oe) begin
            checks++;
            if (bus_out !== (ph == 14 ? 4'h0 : 4'hF)) begin
                errors++;
                $display("FAIL R7/R8 bus_out actual %h expected %h", bus_out, (ph == 14 ? 4'h0 : 4'hF));
            end
        end
        if (wr_valid) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R3/R5/R10 unexpected write actual %h/%h expected none", wr_addr, wr_data);
            end else begin
                e = expq.pop_front();
                if ({wr_addr, wr_data} !== e) begin
                    errors++;
                    $display("FAIL R4/R6 write actual %h/%h expected %h/%h",
                             wr_addr, wr_data, e[35:8], e[7:0]);
                end
            end
        end
    end

    task automatic put(input logic fr, input logic [3:0] n);
        @(negedge clk);
        frame_n = fr;
        bus_in  = n;
    endtask

    // Full write frame; npre extra start nibbles (R2); accept decides queue entry
    task automatic frame(input logic [3:0] id, input logic [27:0] a, input logic [3:0] sz,
                         input logic [7:0] d, input int npre, input logic accept);
        if (accept) expq.push_back({a, d});
        for (int i = 0; i <= npre; i++) put(1'b0, 4'b1110);
        put(1'b1, id);
        for (int i = 6; i >= 0; i--) put(1'b1, a[i*4 +: 4]);
        put(1'b1, sz);
        put(1'b1, d[3:0]);
        put(1'b1, d[7:4]);
        put(1'b1, 4'hF);
        put(1'b1, 4'hF);
        put(1'b1, 4'hF);
        put(1'b1, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if (bus_oe !== 1'b0 || wr_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset actual oe=%b wv=%b expected 0/0", bus_oe, wr_valid);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R4 R6 R8: basic writes with distinct patterns
        frame(4'h5, 28'h1234567, 4'h0, 8'hA5, 0, 1'b1);
        frame(4'h5, 28'hFFFFFFF, 4'h0, 8'h00, 0, 1'b1);
        frame(4'h5, 28'h0000000, 4'h0, 8'hFF, 0, 1'b1);
        frame(4'h5, 28'hA0B0C0D, 4'h0, 8'h3C, 0, 1'b1);

        // R3: ID mismatch
        frame(4'h6, 28'h7654321, 4'h0, 8'h11, 0, 1'b0);
        // R5: unsupported size
        frame(4'h5, 28'h7654321, 4'h1, 8'h22, 0, 1'b0);
        frame(4'h5, 28'h0F0F0F0, 4'h8, 8'h23, 0, 1'b0);

        // R2: repeated starts after a non-start nibble while strobe low
        put(1'b0, 4'b0101);
        frame(4'h5, 28'h2468ACE, 4'h0, 8'h5A, 2, 1'b1);

        // R1: non-start code with strobe low opens nothing
        put(1'b0, 4'b1101);
        put(1'b1, 4'h5);
        for (int i = 0; i < 14; i++) put(1'b1, 4'h0);

        // R10: abort mid-address, then a full frame follows
        put(1'b0, 4'b1110);
        put(1'b1, 4'h5);
        put(1'b1, 4'h9);
        put(1'b1, 4'h9);
        put(1'b1, 4'h9);
        frame(4'h5, 28'h1357BDF, 4'h0, 8'h96, 0, 1'b1);

        // R3: new strap value, back-to-back frames
        id_strap = 4'hC;
        frame(4'h5, 28'h1111111, 4'h0, 8'h01, 0, 1'b0);
        frame(4'hC, 28'h8000001, 4'h0, 8'h80, 0, 1'b1);

        repeat (4) put(1'b1, 4'hF);
        // R9: every queued write delivered exactly once
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R9 pending writes actual %0d expected 0", expq.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule